// File: doc/BRIEF.md
# I2C Tap-Based Bit-Rate Generator

This block produces the serial clock for an I2C master and the moment at which the master may change its data line. A six-bit rate setting is split into two fields. The low field is a tap index. It picks how many tap steps make up half an SCL period, and how many tap steps the data line waits after SCL falls. The high field is a rate exponent. It picks a fixed offset to the first tap and a spacing between taps, and the spacing doubles with each step of the field. The block combines these values into a half-period length and a data hold delay, both counted in system clock cycles.

While enabled, the block runs free. It drives SCL low for half a period, then high for half a period. It raises a one-cycle pulse on the first low cycle of every period, and a one-cycle strobe when the data line may change. Framing, byte shifting, acknowledge handling, arbitration and clock stretching belong to the surrounding controller. A new setting is taken only when a period begins, so no period ever mixes two settings.

Top module: `i2c_tap_rate_gen`

## Requirements
- R1: The tap index field `rate_sel_i[2:0]` selects an SCL tap count of 5, 6, 7, 8, 9, 10, 12, 15 for codes 0..7.
- R2: The same field selects an SDA tap count of 1, 1, 2, 2, 3, 3, 4, 4 for codes 0..7.
- R3: The rate exponent field `rate_sel_i[5:3]` selects a first-tap offset of 4, 4, 6, 6, 14, 30, 62, 126 cycles and a tap spacing of 2^code cycles (1 to 128) for codes 0..7.
- R4: With offset s, spacing t and SCL tap count a, one SCL period is 2*(s+(a-1)*t+2) cycles. SCL is low for the first half and high for the second half, and the two halves are equal.
- R5: `scl_fall_o` is high for exactly one cycle, the first cycle in which SCL is low. It is never high at any other time.
- R6: `sda_upd_o` is a one-cycle strobe that is high exactly s+(b-1)*t+3 cycles after the `scl_fall_o` cycle, where b is the SDA tap count. At that time SCL is still low.
- R7: A change of `rate_sel_i` during a period leaves that period at its old length. The new setting takes effect from the next falling edge of SCL.
- R8: On the first clock edge at which `enable_i` is sampled low, SCL goes high, both strobes go low and the count restarts. They stay that way while `enable_i` remains low.
- R9: After `enable_i` rises, SCL falls at the N-th rising clock edge at which `enable_i` is sampled high, where N is half the selected period.
- R10: While `rst_n` is low, SCL is high and both strobes are low. Reset is applied at once and released through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Runs the generator while high |
| rate_sel_i | input | 6 | Rate setting: [5:3] rate exponent, [2:0] tap index |
| scl_o | output | 1 | SCL level |
| scl_fall_o | output | 1 | One-cycle pulse on the first SCL-low cycle |
| sda_upd_o | output | 1 | One-cycle data-change strobe |

## Verification
All three outputs are registered. A sampled input therefore shows at the outputs one edge later, apart from reset, which acts at once. The data strobe is due `hold` cycles after the fall pulse. SCL rises `divider/2` cycles after it, and the next fall pulse comes `divider` cycles after it. The first fall comes at the N-th edge that samples the enable high. A behavioural reference model in the bench is updated just after every rising edge from the inputs sampled at that edge. The bench compares it with the outputs on the falling edge. Timed measurements taken at falling edges check each latency against values computed from the field tables.

// File: rtl/i2c_rate_pkg.sv
package i2c_rate_pkg;

  localparam int FIELD_W = 3;

  typedef struct packed {
    logic [FIELD_W-1:0] rate_exp;  // offset and spacing selector
    logic [FIELD_W-1:0] tap_idx;   // SCL and SDA tap selector
  } rate_sel_t;

  localparam int SEL_W = $bits(rate_sel_t);

  function automatic int scl_taps(input logic [FIELD_W-1:0] code);
    case (code)
      3'd6:    return 12;
      3'd7:    return 15;
      default: return 5 + int'(code);
    endcase
  endfunction

  function automatic int sda_taps(input logic [FIELD_W-1:0] code);
    return 1 + int'(code >> 1);
  endfunction

  function automatic int first_offset(input logic [FIELD_W-1:0] code);
    case (code)
      3'd0, 3'd1: return 4;
      3'd2:       return 6;
      default:    return (1 << code) - 2;
    endcase
  endfunction

  function automatic int tap_spacing(input logic [FIELD_W-1:0] code);
    return 1 << code;
  endfunction

endpackage

// File: rtl/rate_rst_sync.sv
module rate_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/rate_tap_decode.sv
module rate_tap_decode
  import i2c_rate_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  rate_sel_t        sel_i,
  output logic [CNT_W-1:0] half_o,
  output logic [CNT_W-1:0] hold_o
);

  int offs;
  int step;
  int scl_n;
  int sda_n;

  always_comb begin
    offs   = first_offset(sel_i.rate_exp);
    step   = tap_spacing(sel_i.rate_exp);
    scl_n  = scl_taps(sel_i.tap_idx);
    sda_n  = sda_taps(sel_i.tap_idx);
    // half of the SCL period, then the data hold after the falling edge
    half_o = CNT_W'(offs + (scl_n - 1) * step + 2);
    hold_o = CNT_W'(offs + (sda_n - 1) * step + 3);
  end

endmodule

// File: rtl/rate_phase_ctr.sv
module rate_phase_ctr #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic [CNT_W-1:0] half_i,
  input  logic [CNT_W-1:0] hold_i,
  output logic             scl_o,
  output logic             fall_o,
  output logic             upd_o
);

  logic             scl_q, scl_d;
  logic             fall_q, fall_d;
  logic             upd_q, upd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] half_q, hold_q;
  logic             tim_ld;
  logic             phase_end;

  // next state
  always_comb begin
    scl_d     = scl_q;
    cnt_d     = cnt_q;
    fall_d    = 1'b0;
    upd_d     = 1'b0;
    tim_ld    = 1'b0;
    phase_end = (cnt_q == half_q - CNT_W'(1));
    if (!enable_i) begin
      scl_d  = 1'b1;
      cnt_d  = '0;
      tim_ld = 1'b1;
    end else if (scl_q) begin
      if (phase_end) begin
        scl_d  = 1'b0;
        cnt_d  = '0;
        fall_d = 1'b1;
        tim_ld = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end else begin
      upd_d = (cnt_q == hold_q - CNT_W'(1));
      if (phase_end) begin
        scl_d = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q  <= 1'b1;
      fall_q <= 1'b0;
      upd_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      scl_q  <= scl_d;
      fall_q <= fall_d;
      upd_q  <= upd_d;
      cnt_q  <= cnt_d;
    end
  end

  // timing registers, loaded while idle or when a period begins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= '0;
      hold_q <= '0;
    end else if (tim_ld) begin
      half_q <= half_i;
      hold_q <= hold_i;
    end
  end

  assign scl_o  = scl_q;
  assign fall_o = fall_q;
  assign upd_o  = upd_q;

endmodule

// File: rtl/i2c_tap_rate_gen.sv
module i2c_tap_rate_gen
  import i2c_rate_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic [SEL_W-1:0] rate_sel_i,
  output logic             scl_o,
  output logic             scl_fall_o,
  output logic             sda_upd_o
);

  logic             core_rst_n;
  logic [CNT_W-1:0] half_w;
  logic [CNT_W-1:0] hold_w;
  rate_sel_t        sel_w;

  assign sel_w = rate_sel_t'(rate_sel_i);

  rate_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (core_rst_n)
  );

  rate_tap_decode #(.CNT_W(CNT_W)) u_decode (
    .sel_i  (sel_w),
    .half_o (half_w),
    .hold_o (hold_w)
  );

  rate_phase_ctr #(.CNT_W(CNT_W)) u_phase (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .enable_i (enable_i),
    .half_i   (half_w),
    .hold_i   (hold_w),
    .scl_o    (scl_o),
    .fall_o   (scl_fall_o),
    .upd_o    (sda_upd_o)
  );

endmodule

// File: rtl/i2c_tap_rate_gen_chk.sv
module i2c_tap_rate_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic enable_i,
  input logic scl_o,
  input logic scl_fall_o,
  input logic sda_upd_o
);

  // R5
  fall_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall_o |-> (!scl_o && $past(scl_o)));

  // R5
  fall_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_o) |-> scl_fall_o);

  // R6
  upd_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_upd_o |-> (!scl_o && !scl_fall_o));

  // R6
  upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_upd_o |=> !sda_upd_o);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> (scl_o && !scl_fall_o && !sda_upd_o));

endmodule

bind i2c_tap_rate_gen i2c_tap_rate_gen_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable_i   (enable_i),
  .scl_o      (scl_o),
  .scl_fall_o (scl_fall_o),
  .sda_upd_o  (sda_upd_o)
);

// File: tb/test_i2c_tap_rate_gen.sv
`timescale 1ns/1ps
module test_i2c_tap_rate_gen;

  logic       clk;
  logic       rst_n;
  logic       enable_i;
  logic [5:0] rate_sel_i;
  logic       scl_o, scl_fall_o, sda_upd_o;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  localparam int LIMIT = 150000;

  i2c_tap_rate_gen i_i2c_tap_rate_gen (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .rate_sel_i(rate_sel_i),
    .scl_o(scl_o), .scl_fall_o(scl_fall_o), .sda_upd_o(sda_upd_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  // field tables: R1, R2, R3
  function automatic int t_scl(input int c);
    int v[8] = '{5, 6, 7, 8, 9, 10, 12, 15};
    return v[c];
  endfunction
  function automatic int t_sda(input int c);
    int v[8] = '{1, 1, 2, 2, 3, 3, 4, 4};
    return v[c];
  endfunction
  function automatic int t_off(input int c);
    int v[8] = '{4, 4, 6, 6, 14, 30, 62, 126};
    return v[c];
  endfunction
  function automatic int t_gap(input int c);
    int v[8] = '{1, 2, 4, 8, 16, 32, 64, 128};
    return v[c];
  endfunction
  function automatic int ref_div(input int sel);
    return 2 * (t_off(sel / 8) + (t_scl(sel % 8) - 1) * t_gap(sel / 8) + 2);
  endfunction
  function automatic int ref_hold(input int sel);
    return t_off(sel / 8) + (t_sda(sel % 8) - 1) * t_gap(sel / 8) + 3;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  // behavioural reference: one position counter over the whole period
  int  m_pos = 0, m_div = 20, m_hold = 7, m_sync = 0;
  bit  m_scl = 1, m_fall = 0, m_upd = 0, m_valid = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    if (!rst_n) m_sync = 0;
    else if (m_sync < 3) m_sync++;
    if (!rst_n || m_sync < 3 || !enable_i) begin
      m_div  = ref_div(int'(rate_sel_i));
      m_hold = ref_hold(int'(rate_sel_i));
      m_pos  = m_div / 2;
      m_scl = 1; m_fall = 0; m_upd = 0;
    end else begin
      m_pos++;
      if (m_pos == m_div) begin
        m_pos  = 0;
        m_div  = ref_div(int'(rate_sel_i));
        m_hold = ref_hold(int'(rate_sel_i));
      end
      m_scl  = (m_pos >= m_div / 2);
      m_fall = (m_pos == 0);
      m_upd  = (m_pos == m_hold);
    end
    m_valid = 1;
  end

  always @(negedge clk) begin
    if (m_valid && rst_n) begin
      check(scl_o == m_scl, "R4 model scl", int'(scl_o), int'(m_scl));
      check(scl_fall_o == m_fall, "R5 model scl_fall", int'(scl_fall_o), int'(m_fall));
      check(sda_upd_o == m_upd, "R6 model sda_upd", int'(sda_upd_o), int'(m_upd));
    end
  end

  always @(posedge clk) begin
    if (cyc > LIMIT) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, LIMIT);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wait_fall(output int t);
    do @(negedge clk); while (!scl_fall_o);
    t = cyc;
  endtask

  // measure one full period with a given setting
  task automatic check_rates(input int sel);
    int t0, t1, ts, tr;
    ts = -1; tr = -1;
    @(negedge clk);
    rate_sel_i = 6'(sel);
    wait_fall(t0);
    do begin
      @(negedge clk);
      if (sda_upd_o && ts < 0) ts = cyc;
      if (scl_o && tr < 0) tr = cyc;
    end while (!scl_fall_o);
    t1 = cyc;
    check(t1 - t0 == ref_div(sel), "R1/R3/R4 period", t1 - t0, ref_div(sel));
    check(tr - t0 == ref_div(sel) / 2, "R4 low half", tr - t0, ref_div(sel) / 2);
    check(ts - t0 == ref_hold(sel), "R2/R6 hold", ts - t0, ref_hold(sel));
  endtask

  initial begin
    int n, t0, t1, t2;
    bit quiet;
    rst_n = 1'b0; enable_i = 1'b0; rate_sel_i = 6'd0;
    repeat (4) @(negedge clk);
    // R10 reset state
    check(scl_o == 1'b1, "R10 scl in reset", int'(scl_o), 1);
    check(!scl_fall_o && !sda_upd_o, "R10 strobes in reset",
          int'(scl_fall_o) + int'(sda_upd_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(scl_o == 1'b1, "R10 scl after release", int'(scl_o), 1);

    // R9 first fall after enable
    enable_i = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!scl_fall_o);
    check(n == ref_div(0) / 2, "R9 first fall edges", n, ref_div(0) / 2);

    // R1 R2 R3 R4 R6 several settings
    check_rates(6'h00);
    check_rates(6'h07);
    check_rates(6'h0D);
    check_rates(6'h1A);
    check_rates(6'h22);
    check_rates(6'h3F);

    // R7 mid-period setting change
    @(negedge clk); rate_sel_i = 6'h00;
    wait_fall(t0);
    wait_fall(t0);
    repeat (3) @(negedge clk);
    rate_sel_i = 6'h07;
    wait_fall(t1);
    check(t1 - t0 == ref_div(0), "R7 current period kept", t1 - t0, ref_div(0));
    wait_fall(t2);
    check(t2 - t1 == ref_div(7), "R7 next period new", t2 - t1, ref_div(7));

    // R8 disable during the low half
    wait_fall(t0);
    repeat (3) @(negedge clk);
    enable_i = 1'b0;
    @(negedge clk);
    check(scl_o == 1'b1, "R8 scl after disable", int'(scl_o), 1);
    quiet = 1'b1;
    repeat (40) begin
      @(negedge clk);
      if (!scl_o || scl_fall_o || sda_upd_o) quiet = 1'b0;
    end
    check(quiet, "R8 idle quiet", int'(quiet), 1);

    // R9 re-enable with another setting
    enable_i = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!scl_fall_o);
    check(n == ref_div(7) / 2, "R9 restart edges", n, ref_div(7) / 2);

    // R10 reset during run
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(scl_o == 1'b1 && !sda_upd_o, "R10 async reset", int'(scl_o), 1);
    enable_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule